// File: doc/BRIEF.md
# Deadline-Ordered Response Queue

This block holds pending responses until they are due. Each response comes in with an address, a data word and a due time. A response is never sent before its due time. The queue keeps its entries in order of due time. A new entry is placed by scanning from the tail toward the head, but it never passes an older entry that has the same address. Responses to one address therefore always leave in the order they arrived.

The head entry is offered on a valid/ready output. When the downstream side refuses an offer, the queue stops offering and waits. It offers again only after a pulse on the retry input, and the entry it offers is the same one. The current time is an input, so the queue can share a time base with the rest of the system. A drain request input returns two status outputs: one says entries are still pending, the other says the queue is empty.

Top module: `due_order_queue`

## Requirements
- R1: After reset the queue is empty, `out_valid` is 0, `ins_ready` is 1, and with `drain_req` high `drained` is 1.
- R2: The head entry is offered (`out_valid` = 1) only when `cur_time` is greater than or equal to its due time, compared as unsigned numbers.
- R3: When a new entry's due time is not earlier than the tail's due time, it is appended at the tail, so entries with equal due times leave in arrival order.
- R4: A new entry moves ahead of every tail-side entry whose due time is strictly later and whose address differs, so the output order follows due time.
- R5: A new entry never moves ahead of an entry with the same address, even if that entry's due time is later.
- R6: A new entry never displaces the current head, even if its due time is earlier.
- R7: If `out_valid` is 1 and `out_ready` is 0 at a clock edge, `out_valid` stays 0 from the next cycle until a `retry` pulse. After that pulse the same entry is offered again.
- R8: `ins_ready` is 0 while DEPTH entries are held. While the queue is not full, an insert and a pop in the same cycle both take effect.
- R9: With `drain_req` high, `draining` is 1 while entries remain and `drained` is 1 once the queue is empty.
- R10: A `retry` pulse while no refusal is pending has no effect. A later entry that is due is offered at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_time | input | TIME_W | Current time |
| ins_valid | input | 1 | New response present |
| ins_ready | output | 1 | Queue can accept an entry |
| ins_addr | input | ADDR_W | Address of the new response |
| ins_data | input | DATA_W | Payload of the new response |
| ins_due | input | TIME_W | Earliest send time of the new response |
| out_valid | output | 1 | Head response is offered |
| out_ready | input | 1 | Downstream accepts the offer |
| out_addr | output | ADDR_W | Head address |
| out_data | output | DATA_W | Head payload |
| retry | input | 1 | Downstream asks for the refused head to be offered again |
| drain_req | input | 1 | Drain status requested |
| draining | output | 1 | Drain requested and entries pending |
| drained | output | 1 | Drain requested and queue empty |

## Verification
The main sweep fills the four-entry queue with every combination of due times from a set of three values and every pattern of two addresses. It then releases all entries. This separates plain tail appends, moves ahead by due time, stops at a matching address and the head guard, all within a single pass. Directed sequences then cover the remaining behaviour:
- the due-time edge, one step before and on the due time;
- a refusal followed by waiting and a retry;
- a stray retry while nothing was refused;
- a pop and an insert in the same cycle;
- the drain status through filling and emptying.

// File: rtl/dq_place.sv
module dq_place #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8,
  parameter int TIME_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] q_addr,
  input  logic [DEPTH-1:0][TIME_W-1:0] q_due,
  input  logic [CNT_W-1:0]             q_cnt,
  input  logic [ADDR_W-1:0]            new_addr,
  input  logic [TIME_W-1:0]            new_due,
  output logic [CNT_W-1:0]             slot
);
  // Slot is one past the tail-most entry that the new entry may not pass;
  // index 0 (the head) is never examined, so slot >= 1 when not empty.
  always_comb begin
    slot = (q_cnt == '0) ? '0 : CNT_W'(1);
    for (int i = 1; i < DEPTH; i++) begin
      if (CNT_W'(i) < q_cnt &&
          !(new_due < q_due[i] && new_addr != q_addr[i]))
        slot = CNT_W'(i + 1);
    end
  end
endmodule

// File: rtl/dq_store.sv
module dq_store #(
  parameter int DEPTH = 4,
  parameter int EW    = 32,
  parameter int CNT_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     put,
  input  logic [CNT_W-1:0]         slot,
  input  logic [EW-1:0]            new_ent,
  input  logic                     pop,
  output logic [DEPTH-1:0][EW-1:0] q_ent,
  output logic [CNT_W-1:0]         q_cnt
);
  logic [DEPTH:0][EW-1:0] lo, hi, merged;
  logic [CNT_W-1:0]       slot_eff;

  assign slot_eff = put ? slot : CNT_W'(DEPTH + 1);

  generate
    for (genvar j = 0; j <= DEPTH; j++) begin : g_ext
      if (j < DEPTH) begin : g_lo
        assign lo[j] = q_ent[j];
      end else begin : g_lo_pad
        assign lo[j] = '0;
      end
      if (j > 0) begin : g_hi
        assign hi[j] = q_ent[j-1];
      end else begin : g_hi_pad
        assign hi[j] = '0;
      end
      assign merged[j] = (CNT_W'(j) < slot_eff) ? lo[j] :
                         (CNT_W'(j) == slot_eff) ? new_ent : hi[j];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q_cnt <= '0;
      q_ent <= '0;
    end else begin
      for (int j = 0; j < DEPTH; j++)
        q_ent[j] <= pop ? merged[j+1] : merged[j];
      q_cnt <= q_cnt + CNT_W'(put) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/dq_offer.sv
module dq_offer #(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              have,
  input  logic [TIME_W-1:0] head_due,
  input  logic [TIME_W-1:0] now,
  input  logic              out_ready,
  input  logic              retry,
  output logic              out_valid,
  output logic              pop
);
  logic held;

  assign out_valid = have && !held && (now >= head_due);
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst)                        held <= 1'b0;
    else if (out_valid && !out_ready) held <= 1'b1;
    else if (retry)                 held <= 1'b0;
  end
endmodule

// File: rtl/due_order_queue.sv
module due_order_queue #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] cur_time,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [DATA_W-1:0] ins_data,
  input  logic [TIME_W-1:0] ins_due,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  input  logic              retry,
  input  logic              drain_req,
  output logic              draining,
  output logic              drained
);
  localparam int EW    = TIME_W + ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(DEPTH + 2);

  logic [DEPTH-1:0][EW-1:0]     q_ent;
  logic [DEPTH-1:0][ADDR_W-1:0] q_addr;
  logic [DEPTH-1:0][TIME_W-1:0] q_due;
  logic [CNT_W-1:0]             cnt, slot;
  logic                         put, pop;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_split
      assign q_due[i]  = q_ent[i][EW-1 -: TIME_W];
      assign q_addr[i] = q_ent[i][DATA_W +: ADDR_W];
    end
  endgenerate

  assign ins_ready = (cnt != CNT_W'(DEPTH));
  assign put       = ins_valid && ins_ready;
  assign out_addr  = q_addr[0];
  assign out_data  = q_ent[0][DATA_W-1:0];
  assign draining  = drain_req && (cnt != '0);
  assign drained   = drain_req && (cnt == '0);

  dq_place #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TIME_W(TIME_W), .CNT_W(CNT_W)) u_place (
    .q_addr(q_addr), .q_due(q_due), .q_cnt(cnt),
    .new_addr(ins_addr), .new_due(ins_due), .slot(slot)
  );

  dq_store #(.DEPTH(DEPTH), .EW(EW), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst), .put(put), .slot(slot),
    .new_ent({ins_due, ins_addr, ins_data}), .pop(pop),
    .q_ent(q_ent), .q_cnt(cnt)
  );

  dq_offer #(.TIME_W(TIME_W)) u_offer (
    .clk(clk), .rst(rst), .have(cnt != '0), .head_due(q_due[0]),
    .now(cur_time), .out_ready(out_ready), .retry(retry),
    .out_valid(out_valid), .pop(pop)
  );
endmodule

// File: rtl/dq_checker.sv
module dq_checker #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  cnt,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [DATA_W-1:0] out_data,
  input logic              drained
);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

  assert_insert_grows_R8: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_ready && !(out_valid && out_ready)) |=> cnt == $past(cnt) + CNT_W'(1));

  assert_hold_after_refuse_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> !out_valid);

  assert_head_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_addr)));

  assert_drained_idle_R9: assert property (@(posedge clk) disable iff (rst)
    drained |-> !out_valid);
endmodule

bind due_order_queue dq_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W($clog2(DEPTH + 2))
) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
  .out_data(out_data), .drained(drained)
);

// File: tb/due_order_queue_test.sv
module due_order_queue_test;
  localparam int DEPTH = 4, AW = 8, DW = 8, TW = 16;

  logic clk = 0, rst = 1;
  logic [TW-1:0] cur_time = '0;
  logic ins_valid = 0, out_ready = 0, retry = 0, drain_req = 0;
  logic [AW-1:0] ins_addr = '0;
  logic [DW-1:0] ins_data = '0;
  logic [TW-1:0] ins_due = '0;
  logic ins_ready, out_valid, draining, drained;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;

  int n_chk = 0, n_fail = 0;
  int m_data [0:DEPTH];
  int m_addr [0:DEPTH];
  int m_due  [0:DEPTH];
  int mcnt = 0;

  always #5 clk = ~clk;

  due_order_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .TIME_W(TW)) uut (
    .clk(clk), .rst(rst), .cur_time(cur_time), .ins_valid(ins_valid),
    .ins_ready(ins_ready), .ins_addr(ins_addr), .ins_data(ins_data),
    .ins_due(ins_due), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_data(out_data), .retry(retry),
    .drain_req(drain_req), .draining(draining), .drained(drained)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(int addr, int data, int due);
    ins_valid = 1; ins_addr = AW'(addr); ins_data = DW'(data); ins_due = TW'(due);
    step();
    ins_valid = 0;
  endtask

  // Release n entries at a late time and compare payload order.
  task automatic expect_order(string req, int n, int e0, int e1, int e2, int e3);
    int exp [4];
    exp = '{e0, e1, e2, e3};
    cur_time = 1000; out_ready = 1;
    for (int i = 0; i < n; i++) begin
      #1;
      check(req, out_valid, 1);
      check(req, out_data, exp[i]);
      step();
    end
    #1; check(req, out_valid, 0);
    out_ready = 0; cur_time = 0;
  endtask

  task automatic model_insert(int addr, int data, int due);
    int k;
    k = mcnt;
    while (k > 1 && due < m_due[k-1] && addr != m_addr[k-1]) k--;
    for (int j = mcnt; j > k; j--) begin
      m_data[j] = m_data[j-1]; m_addr[j] = m_addr[j-1]; m_due[j] = m_due[j-1];
    end
    m_data[k] = data; m_addr[k] = addr; m_due[k] = due;
    mcnt++;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    drain_req = 1;
    repeat (3) @(posedge clk);
    #1; rst = 0; #1;
    check("R1 out_valid", out_valid, 0);
    check("R1 ins_ready", ins_ready, 1);
    check("R1 drained", drained, 1);
    check("R1 draining", draining, 0);

    // Sweep: all due patterns in {1,2,3}^4 x all two-address patterns
    for (int s = 0; s < 81; s++) begin
      for (int ap = 0; ap < 16; ap++) begin
        int p;
        mcnt = 0; p = 1;
        for (int e = 0; e < DEPTH; e++) begin
          int due, addr;
          due = 1 + (s / p) % 3; p = p * 3;
          addr = (ap >> e) & 1;
          push(addr, e, due);
          model_insert(addr, e, due);
        end
        check("R8 full", ins_ready, 0);
        check("R2 early", out_valid, 0);
        cur_time = 10; out_ready = 1;
        for (int e = 0; e < DEPTH; e++) begin
          #1;
          check("R4 sweep valid", out_valid, 1);
          check("R4 sweep order", out_data, m_data[e]);
          step();
        end
        out_ready = 0; cur_time = 0;
      end
    end

    // R3: equal due times keep arrival order
    push(5, 11, 2); push(6, 12, 2); push(7, 13, 2);
    expect_order("R3", 3, 11, 12, 13, 0);

    // R4: earlier due moves ahead of later, differing address
    push(1, 21, 9); push(2, 22, 8); push(3, 23, 7); push(4, 24, 3);
    expect_order("R4", 4, 21, 24, 23, 22);

    // R5: same address stops the scan
    push(1, 31, 9); push(3, 32, 9); push(4, 33, 9); push(3, 34, 4);
    expect_order("R5", 4, 31, 32, 34, 33);

    // R6: head never displaced
    push(1, 41, 9); push(2, 42, 1);
    expect_order("R6", 2, 41, 42, 0, 0);

    // R2: due-time edge
    cur_time = 3; push(1, 55, 5);
    check("R2 before", out_valid, 0);
    cur_time = 4; #1; check("R2 one short", out_valid, 0);
    cur_time = 5; #1; check("R2 on time", out_valid, 1);
    check("R2 data", out_data, 55);
    out_ready = 1; step(); out_ready = 0; cur_time = 0;
    #1; check("R2 emptied", out_valid, 0);

    // R7: refuse, wait, retry, same entry again
    push(2, 77, 0);
    check("R7 offered", out_valid, 1);
    step();
    check("R7 after refuse", out_valid, 0);
    step(); step();
    check("R7 still waiting", out_valid, 0);
    retry = 1; step(); retry = 0;
    check("R7 reoffered", out_valid, 1);
    check("R7 same entry", out_data, 77);
    out_ready = 1; step(); out_ready = 0;

    // R10: stray retry with nothing refused
    retry = 1; step(); retry = 0;
    push(3, 88, 0);
    check("R10 offered", out_valid, 1);
    check("R10 data", out_data, 88);
    out_ready = 1; step(); out_ready = 0;

    // R8: pop and insert in the same cycle
    push(1, 61, 5); push(2, 62, 5);
    cur_time = 5; out_ready = 1;
    ins_valid = 1; ins_addr = 3; ins_data = 63; ins_due = 5;
    #1; check("R8 pop side", out_data, 61);
    step(); ins_valid = 0; out_ready = 0;
    expect_order("R8", 2, 62, 63, 0, 0);

    // R9: drain status
    #1; check("R9 empty drained", drained, 1);
    push(1, 91, 5);
    check("R9 draining", draining, 1);
    check("R9 not drained", drained, 0);
    cur_time = 5; out_ready = 1; step(); out_ready = 0;
    check("R9 drained again", drained, 1);
    check("R9 not draining", draining, 0);

    finish_run();
  end
endmodule